// File: doc/BRIEF.md
# Sixteen-Bit Arithmetic Unit with Overflow Register

This block is the execute stage of a small 16-bit processor. It gets two operand values and a 4-bit operation code. One clock later it returns the result, a write-enable for the destination, the cost of the operation in machine cycles and a flag that tells the sequencer to skip the next instruction. It also holds the 16-bit overflow register. Each arithmetic operation gives that register a defined value, so software can recover carries, borrows, high product halves, fractional quotients and shifted-out bits.

Division and modulo by zero do not trap. They produce zero. The caller marks a destination that is a literal, and the block then drops the write but still applies the overflow update. The four test operations write nothing. They only decide whether the next instruction runs. Operand fetch, memory access and instruction sequencing belong to the surrounding core.

Top module: `alu16_ovf`

## Requirements
- R1: Operation code 0x2 (add) returns (a+b) mod 65536. The overflow register becomes 0x0001 when the true sum is above 0xffff, and 0x0000 otherwise.
- R2: Operation code 0x3 (subtract) returns (a-b) mod 65536. The overflow register becomes 0xffff when b is greater than a, and 0x0000 otherwise.
- R3: Operation code 0x4 (multiply) returns the low 16 bits of the 32-bit product, and the overflow register takes the high 16 bits.
- R4: Operation code 0x5 (divide) with nonzero b returns floor(a/b), and the overflow register takes the low 16 bits of floor(a*65536/b). With b equal to zero, both the result and the overflow register become 0.
- R5: Operation code 0x6 (modulo) returns a mod b, or 0 when b is zero, and leaves the overflow register unchanged.
- R6: Operation code 0x7 (shift left) returns the low 16 bits of a shifted left by b, and the overflow register takes bits 31..16 of that shift in 32 bits. Operation code 0x8 (shift right) returns a>>b, and the overflow register takes the low 16 bits of (a*65536)>>b. A shift of 16 or more gives a zero result.
- R7: Operation codes 0x9 (and), 0xA (or) and 0xB (xor) return the bitwise result and leave the overflow register unchanged.
- R8: Operation codes 0xC (a==b), 0xD (a!=b), 0xE (a>b, unsigned) and 0xF ((a&b)!=0) raise the skip flag when the test is false. They return result 0, never assert the write-enable and leave the overflow register unchanged.
- R9: When dst_literal is set, the write-enable stays low, but the overflow register is still updated. Otherwise the write-enable is high for codes 0x2 to 0xB.
- R10: The reported cost is 1 for and/or/xor, 2 for add, subtract, multiply, both shifts and the tests, 3 for divide and modulo, and 0 for codes 0x0 and 0x1.
- R11: An operation that is presented with op_valid high at a rising edge shows its outputs from that edge on, with done_q high for one cycle. In a cycle with op_valid low, done_q, wr_en_q, skip_q and cost_q are 0, and res_q and ovf_q hold. Codes 0x0 and 0x1 give result 0, no write, no skip and no change to the overflow register.
- R12: While rst_n is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Operation code |
| a_val | input | 16 | Destination operand value |
| b_val | input | 16 | Source operand value |
| dst_literal | input | 1 | The destination is a literal, so the write is suppressed |
| res_q | output | 16 | Registered result |
| wr_en_q | output | 1 | Write the result back to the destination |
| ovf_q | output | 16 | Overflow register |
| cost_q | output | 2 | Cycle cost of the completed operation |
| skip_q | output | 1 | Skip the next instruction |
| done_q | output | 1 | An operation completed |

## Verification
The bench targets division and modulo by zero. A design that trapped or passed a through would leave a nonzero result, or a stale overflow value after a divide. It exercises shift amounts of 16, 20 and 40. These expose a design that wraps the shift amount or drops the bits moved into the overflow register. It checks that modulo, the logic operations and the tests keep the previous overflow value, which a design that clears it on every operation would destroy. It also runs add with carry to a literal destination, where a correct design updates the overflow register but raises no write.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  localparam int COST_W = 2;

  typedef enum logic [3:0] {
    OPC_RSV0 = 4'h0, OPC_RSV1 = 4'h1,
    OPC_ADD  = 4'h2, OPC_SUB  = 4'h3, OPC_MUL  = 4'h4,
    OPC_DIV  = 4'h5, OPC_MOD  = 4'h6, OPC_SHL  = 4'h7,
    OPC_SHR  = 4'h8, OPC_AND  = 4'h9, OPC_IOR  = 4'hA,
    OPC_XOR  = 4'hB, OPC_TEQ  = 4'hC, OPC_TNE  = 4'hD,
    OPC_TGT  = 4'hE, OPC_TBIT = 4'hF
  } opc_e;

  function automatic logic [COST_W-1:0] op_cost(opc_e op);
    case (op)
      OPC_AND, OPC_IOR, OPC_XOR: op_cost = COST_W'(1);
      OPC_DIV, OPC_MOD:          op_cost = COST_W'(3);
      OPC_RSV0, OPC_RSV1:        op_cost = COST_W'(0);
      default:                   op_cost = COST_W'(2);
    endcase
  endfunction

  function automatic logic op_writes(opc_e op);
    op_writes = (op >= OPC_ADD) && (op <= OPC_XOR);
  endfunction

  function automatic logic op_is_test(opc_e op);
    op_is_test = (op >= OPC_TEQ);
  endfunction

  function automatic logic op_sets_o(opc_e op);
    op_sets_o = (op >= OPC_ADD) && (op <= OPC_SHR) && (op != OPC_MOD);
  endfunction

endpackage

// File: rtl/alu16_arith.sv
module alu16_arith
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  opc_e         op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output logic [W-1:0] o_val
);
  localparam int WW = 2 * W;

  logic [W:0]    sum_w;
  logic [W:0]    diff_w;
  logic [WW-1:0] prod_w;
  logic [WW-1:0] shl_w;
  logic [WW-1:0] shr_w;

  assign sum_w  = {1'b0, a} + {1'b0, b};
  assign diff_w = {1'b0, a} - {1'b0, b};
  assign prod_w = {{W{1'b0}}, a} * {{W{1'b0}}, b};
  assign shl_w  = {{W{1'b0}}, a} << b;
  assign shr_w  = {a, {W{1'b0}}} >> b;

  always_comb begin
    res   = '0;
    o_val = '0;
    case (op)
      OPC_ADD: begin
        res   = sum_w[W-1:0];
        o_val = {{(W-1){1'b0}}, sum_w[W]};
      end
      OPC_SUB: begin
        res   = diff_w[W-1:0];
        o_val = {W{diff_w[W]}};
      end
      OPC_MUL: begin
        res   = prod_w[W-1:0];
        o_val = prod_w[WW-1:W];
      end
      OPC_SHL: begin
        res   = shl_w[W-1:0];
        o_val = shl_w[WW-1:W];
      end
      OPC_SHR: begin
        res   = shr_w[WW-1:W];
        o_val = shr_w[W-1:0];
      end
      default: begin
        res   = '0;
        o_val = '0;
      end
    endcase
  end
endmodule

// File: rtl/alu16_divmod.sv
module alu16_divmod #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         div_zero,
  output logic [W-1:0] quo,
  output logic [W-1:0] quo_frac,
  output logic [W-1:0] rem
);
  localparam int WW = 2 * W;

  logic [WW-1:0] wide_q;

  assign div_zero = (b == '0);
  assign wide_q   = div_zero ? '0 : ({a, {W{1'b0}}} / {{W{1'b0}}, b});
  assign quo      = wide_q[WW-1:W];
  assign quo_frac = wide_q[W-1:0];
  assign rem      = div_zero ? '0 : (a % b);
endmodule

// File: rtl/alu16_bitcond.sv
module alu16_bitcond
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  opc_e         op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output logic         test_pass
);
  always_comb begin
    case (op)
      OPC_AND: res = a & b;
      OPC_IOR: res = a | b;
      OPC_XOR: res = a ^ b;
      default: res = '0;
    endcase
  end

  always_comb begin
    case (op)
      OPC_TEQ:  test_pass = (a == b);
      OPC_TNE:  test_pass = (a != b);
      OPC_TGT:  test_pass = (a > b);
      OPC_TBIT: test_pass = ((a & b) != '0);
      default:  test_pass = 1'b1;
    endcase
  end
endmodule

// File: rtl/alu16_ovf.sv
module alu16_ovf
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [3:0]        op_code,
  input  logic [W-1:0]      a_val,
  input  logic [W-1:0]      b_val,
  input  logic              dst_literal,
  output logic [W-1:0]      res_q,
  output logic              wr_en_q,
  output logic [W-1:0]      ovf_q,
  output logic [COST_W-1:0] cost_q,
  output logic              skip_q,
  output logic              done_q
);
  opc_e          op_e;
  logic [W-1:0]  ar_res, ar_o;
  logic [W-1:0]  dv_quo, dv_frac, dv_rem;
  logic          div_zero;
  logic [W-1:0]  bc_res;
  logic          test_pass;
  logic [W-1:0]  nxt_res, nxt_o;
  logic          nxt_wr, nxt_skip;
  logic          o_upd;

  assign op_e = opc_e'(op_code);

  alu16_arith #(.W(W)) u_arith (
    .op(op_e), .a(a_val), .b(b_val), .res(ar_res), .o_val(ar_o)
  );

  alu16_divmod #(.W(W)) u_divmod (
    .a(a_val), .b(b_val), .div_zero(div_zero),
    .quo(dv_quo), .quo_frac(dv_frac), .rem(dv_rem)
  );

  alu16_bitcond #(.W(W)) u_bitcond (
    .op(op_e), .a(a_val), .b(b_val), .res(bc_res), .test_pass(test_pass)
  );

  always_comb begin
    nxt_res = '0;
    nxt_o   = ar_o;
    case (op_e)
      OPC_ADD, OPC_SUB, OPC_MUL, OPC_SHL, OPC_SHR: nxt_res = ar_res;
      OPC_DIV: begin
        nxt_res = div_zero ? '0 : dv_quo;
        nxt_o   = div_zero ? '0 : dv_frac;
      end
      OPC_MOD:                   nxt_res = dv_rem;
      OPC_AND, OPC_IOR, OPC_XOR: nxt_res = bc_res;
      default:                   nxt_res = '0;
    endcase
  end

  assign nxt_wr   = op_writes(op_e) && !dst_literal;
  assign nxt_skip = op_is_test(op_e) && !test_pass;
  assign o_upd    = op_valid && op_sets_o(op_e);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q   <= '0;
      wr_en_q <= 1'b0;
      ovf_q   <= '0;
      cost_q  <= '0;
      skip_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= op_valid;
      if (op_valid) begin
        res_q   <= nxt_res;
        wr_en_q <= nxt_wr;
        skip_q  <= nxt_skip;
        cost_q  <= op_cost(op_e);
      end else begin
        wr_en_q <= 1'b0;
        skip_q  <= 1'b0;
        cost_q  <= '0;
      end
      if (o_upd) ovf_q <= nxt_o;
    end
  end
endmodule

// File: rtl/alu16_ovf_chk.sv
module alu16_ovf_chk #(
  parameter int W = 16,
  parameter int CW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic [3:0]    op_code,
  input logic [W-1:0]  b_val,
  input logic          dst_literal,
  input logic [W-1:0]  res_q,
  input logic          wr_en_q,
  input logic [W-1:0]  ovf_q,
  input logic [CW-1:0] cost_q,
  input logic          skip_q,
  input logic          done_q,
  input logic          o_upd
);
  p_lit_nowrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && dst_literal) |=> !wr_en_q);

  p_logic_keeps_o_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code >= 4'h9 && op_code <= 4'hB) |=> $stable(ovf_q));

  p_div_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'h5 && b_val == '0) |=> (res_q == '0 && ovf_q == '0));

  p_mod_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'h6 && b_val == '0) |=> (res_q == '0));

  p_add_carry_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'h2) |=> (ovf_q <= W'(1)));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!done_q && !wr_en_q && !skip_q && cost_q == '0));

  p_test_nowrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code >= 4'hC) |=> (!wr_en_q && $stable(ovf_q)));

  p_skip_needs_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    skip_q |-> done_q);

  p_o_only_on_update_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !o_upd |=> $stable(ovf_q));
endmodule

bind alu16_ovf alu16_ovf_chk #(.W(W), .CW(alu16_pkg::COST_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .b_val(b_val), .dst_literal(dst_literal), .res_q(res_q), .wr_en_q(wr_en_q),
  .ovf_q(ovf_q), .cost_q(cost_q), .skip_q(skip_q), .done_q(done_q), .o_upd(o_upd)
);

// File: tb/sim_alu16_ovf.sv
module sim_alu16_ovf;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = '0;
  logic [15:0] a_val = '0;
  logic [15:0] b_val = '0;
  logic        dst_literal = 1'b0;
  logic [15:0] res_q, ovf_q;
  logic [1:0]  cost_q;
  logic        wr_en_q, skip_q, done_q;

  int checks = 0;
  int errors = 0;

  // reference state
  int unsigned m_res = 0;
  int unsigned m_o = 0;

  always #5 clk = ~clk;

  alu16_ovf u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .a_val(a_val), .b_val(b_val), .dst_literal(dst_literal),
    .res_q(res_q), .wr_en_q(wr_en_q), .ovf_q(ovf_q), .cost_q(cost_q),
    .skip_q(skip_q), .done_q(done_q)
  );

  function automatic string tag_of(bit v, int op);
    if (!v) return "R11";
    case (op)
      2: return "R1";
      3: return "R2";
      4: return "R3";
      5: return "R4";
      6: return "R5";
      7, 8: return "R6";
      9, 10, 11: return "R7";
      12, 13, 14, 15: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic step(input bit v, input int op, input int unsigned a,
                      input int unsigned b, input bit lit);
    longint unsigned w;
    int unsigned e_res, e_o, e_cost;
    bit e_wr, e_skip, pass;
    string t;
    op_valid = v; op_code = 4'(op); a_val = 16'(a); b_val = 16'(b); dst_literal = lit;
    e_res = m_res; e_o = m_o; e_cost = 0; e_wr = 0; e_skip = 0;
    if (v) begin
      e_res = 0;
      case (op)
        2: begin e_res = (a + b) & 16'hffff; e_o = ((a + b) > 65535) ? 1 : 0; e_cost = 2; end
        3: begin e_res = (a - b) & 16'hffff; e_o = (b > a) ? 16'hffff : 0; e_cost = 2; end
        4: begin w = longint'(a) * longint'(b); e_res = int'(w & 16'hffff); e_o = int'(w >> 16); e_cost = 2; end
        5: begin
          if (b == 0) begin e_res = 0; e_o = 0; end
          else begin e_res = a / b; e_o = int'(((longint'(a) * 65536) / b) & 16'hffff); end
          e_cost = 3;
        end
        6: begin e_res = (b == 0) ? 0 : a % b; e_cost = 3; end
        7: begin w = (longint'(a) << b) & 64'hffffffff; e_res = int'(w & 16'hffff); e_o = int'(w >> 16); e_cost = 2; end
        8: begin w = (longint'(a) << 16) >> b; e_res = int'(w >> 16); e_o = int'(w & 16'hffff); e_cost = 2; end
        9:  begin e_res = a & b; e_cost = 1; end
        10: begin e_res = a | b; e_cost = 1; end
        11: begin e_res = a ^ b; e_cost = 1; end
        12: begin e_skip = !(a == b); e_cost = 2; end
        13: begin e_skip = !(a != b); e_cost = 2; end
        14: begin e_skip = !(a > b); e_cost = 2; end
        15: begin e_skip = !((a & b) != 0); e_cost = 2; end
        default: e_cost = 0;
      endcase
      e_wr = (op >= 2 && op <= 11) && !lit;
    end
    m_res = e_res; m_o = e_o;
    @(posedge clk);
    @(negedge clk);
    t = tag_of(v, op);
    checks++;
    pass = (res_q == 16'(e_res)) && (ovf_q == 16'(e_o)) && (skip_q == e_skip) && (done_q == v);
    if (!pass) begin
      errors++;
      $display("FAIL %s op=%0h a=%h b=%h: res=%h ovf=%h skip=%b done=%b expected res=%h ovf=%h skip=%b done=%b",
               t, op, a, b, res_q, ovf_q, skip_q, done_q, 16'(e_res), 16'(e_o), e_skip, v);
    end
    checks++;
    if (wr_en_q != e_wr) begin
      errors++;
      $display("FAIL %s wr_en op=%0h lit=%b: got %b expected %b", lit ? "R9" : t, op, lit, wr_en_q, e_wr);
    end
    checks++;
    if (cost_q != 2'(e_cost)) begin
      errors++;
      $display("FAIL R10 cost op=%0h: got %0d expected %0d", op, cost_q, e_cost);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired: got hang expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    checks++;
    if (res_q !== 0 || ovf_q !== 0 || wr_en_q !== 0 || cost_q !== 0 || skip_q !== 0 || done_q !== 0) begin
      errors++;
      $display("FAIL R12 reset: res=%h ovf=%h wr=%b cost=%0d skip=%b done=%b expected all zero",
               res_q, ovf_q, wr_en_q, cost_q, skip_q, done_q);
    end
    rst_n = 1'b1;
    // R1 add
    step(1, 2, 16'hffff, 1, 0);
    step(1, 2, 1, 2, 0);
    // R2 subtract
    step(1, 3, 0, 1, 0);
    step(1, 3, 5, 5, 0);
    // R3 multiply
    step(1, 4, 16'hffff, 16'hffff, 0);
    step(1, 4, 16'h0100, 16'h0100, 0);
    // R4 divide
    step(1, 5, 7, 0, 0);
    step(1, 5, 1, 3, 0);
    step(1, 5, 16'hffff, 1, 0);
    // R5 modulo keeps O (O is 0 here after ffff/1; set a nonzero first)
    step(1, 4, 16'h1234, 16'h0100, 0);
    step(1, 6, 7, 0, 0);
    step(1, 6, 17, 5, 0);
    // R6 shifts
    step(1, 7, 16'h8001, 1, 0);
    step(1, 7, 16'habcd, 16, 0);
    step(1, 7, 16'habcd, 40, 0);
    step(1, 8, 3, 1, 0);
    step(1, 8, 16'hf00f, 20, 0);
    step(1, 8, 16'h8000, 16, 0);
    // R7 logic keeps O
    step(1, 9, 16'hff00, 16'h0ff0, 0);
    step(1, 10, 16'hff00, 16'h0ff0, 0);
    step(1, 11, 16'hff00, 16'h0ff0, 0);
    // R8 tests, pass and fail
    step(1, 12, 5, 5, 0);
    step(1, 12, 5, 6, 0);
    step(1, 13, 5, 5, 0);
    step(1, 14, 16'h8000, 16'h7fff, 0);
    step(1, 14, 3, 3, 0);
    step(1, 15, 16'h00f0, 16'h000f, 0);
    step(1, 15, 16'h00f0, 16'h0010, 0);
    // R9 literal destination: no write, O still updated
    step(1, 2, 16'hffff, 16'hffff, 1);
    step(1, 5, 0, 0, 1);
    step(1, 3, 1, 2, 1);
    // R11 idle and reserved codes
    step(0, 2, 1, 1, 0);
    step(1, 0, 1, 2, 0);
    step(1, 1, 9, 9, 0);
    step(0, 0, 0, 0, 0);
    // mixed patterns, covering R10 costs for all codes
    for (int i = 0; i < 400; i++) begin
      int unsigned ra, rb;
      ra = $urandom & 16'hffff;
      rb = $urandom & 16'hffff;
      if (($urandom % 8) == 0) rb = 0;
      if (($urandom % 4) == 0) rb = rb % 24;
      step(($urandom % 6) != 0, int'($urandom % 16), ra, rb, ($urandom % 5) == 0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule